// File: doc/BRIEF.md
# Eight-Input Programmable Interrupt Controller

This block gathers eight interrupt request lines into one interrupt output for a processor. Software programs it through a two-address register port. A write at the even address with bit 4 set starts a fixed initialization sequence. The odd address then takes the vector base, an optional cascade map and an optional options word. Only after that sequence is complete does the controller raise its interrupt output.

Once it is running, the block records requests on edges or on levels. It keeps separate request, in-service and mask registers and arbitrates with a fixed order in which input 0 is the highest. An acknowledge pulse returns the vector of the winning input on the next cycle.

In cascade mode, a map marks the inputs that have a second controller attached. An acknowledge of such an input raises a select flag, so that a master and one slave can serve fifteen lines. End of interrupt is either a non-specific command from software or automatic at acknowledge time.

Top module: `prog_irq_ctrl`

## Requirements
- R1: After reset `int_o`, `vec_valid` and `cas_sel` are 0 and the controller waits for the first initialization word. Odd-address writes before that word are ignored.
- R2: A write at the even address (`addr`=0) with `wdata[4]`=1 is the first initialization word, accepted at any time. Its `wdata[3]` selects level (1) or edge (0) detection, `wdata[1]` selects single (1) or cascade (0) operation, and `wdata[0]` requests the options word. The write clears the in-service, mask and request registers.
- R3: After the first word, the odd-address writes are taken in this order: the vector base, then the slave map (cascade only), then the options word (only if requested). `int_o` stays 0 until the sequence ends. When the options word is skipped, all of its options are 0.
- R4: The vector is `{base word[7:3], index of the winning input}`; for example, a base of 40h with input 5 gives 45h.
- R5: After initialization, an odd-address write loads the mask register. A masked input never raises `int_o`, but its recorded request is kept and raises `int_o` once the input is unmasked.
- R6: In edge mode a request is recorded on a low-to-high change of an input and held until it is acknowledged. An input held high does not record again.
- R7: In level mode the request register follows the input level each cycle.
- R8: Priority is fixed, with input 0 the highest. `int_o` is 1 only when the best unmasked request has a higher priority than every in-service bit.
- R9: When `ack` is 1 while `int_o` is 1, on the next cycle `vec_valid` pulses for one cycle with the vector. The winner's request bit is cleared and its in-service bit is set. When `ack` is 1 while `int_o` is 0, nothing happens.
- R10: When options word bit 1 (automatic end of interrupt) is set, an acknowledge leaves no in-service bit behind.
- R11: An even-address write with `wdata[7:5]`=001 and `wdata[4:3]`=00 clears the highest-priority in-service bit.
- R12: `cas_sel` is 1 together with `vec_valid` when the acknowledged input is set in the slave map and the block is in cascade mode. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | Register address (0 even, 1 odd) |
| wdata | input | 8 | Write data |
| irq_in | input | 8 | Interrupt request lines, bit 0 highest priority |
| ack | input | 1 | Acknowledge pulse from the processor |
| int_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Vector of the acknowledged input |
| vec_valid | output | 1 | Vector strobe, one cycle after an accepted acknowledge |
| cas_sel | output | 1 | Acknowledged input belongs to a slave |

## Verification
If the sequencer is in the wrong state, writes go to the wrong place. This appears as a wrong vector base or a wrong cascade flag at the very next acknowledge, or as `int_o` staying low after what should be the last initialization word. A stuck or wrongly cleared in-service bit appears at once as `int_o` holding off lower-priority requests, or releasing them too early. The bench therefore checks `int_o` on the cycle after every request change, every end-of-interrupt write and every acknowledge. It compares each vector strobe against an expected queue.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [2:0] {
    ST_WAIT1,
    ST_BASE,
    ST_SLAVE,
    ST_OPTS,
    ST_RUN
  } seq_state_e;

  localparam int CMD_W = 8;
endpackage

// File: rtl/pic_init_seq.sv
module pic_init_seq
  import pic_pkg::*;
#(
  parameter int NUM_IN = 8,
  parameter int BASE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              addr,
  input  logic [CMD_W-1:0]  wdata,
  output logic              ready,
  output logic              start_stb,
  output logic              mask_stb,
  output logic              eoi_stb,
  output logic              level_mode,
  output logic              cascade,
  output logic              aeoi,
  output logic [BASE_W-1:0] base,
  output logic [NUM_IN-1:0] slave_map
);
  localparam int IDX_W = CMD_W - BASE_W;

  seq_state_e        st_q, st_n;
  logic              level_q, level_n;
  logic              single_q, single_n;
  logic              need_opts_q, need_opts_n;
  logic              aeoi_q, aeoi_n;
  logic [BASE_W-1:0] base_q, base_n;
  logic [NUM_IN-1:0] smap_q, smap_n;
  logic              wr_even, wr_odd;
  logic              cfg_unused;

  assign wr_even    = wr_en & ~addr;
  assign wr_odd     = wr_en & addr;
  assign start_stb  = wr_even & wdata[4];
  assign ready      = (st_q == ST_RUN);
  assign mask_stb   = wr_odd & ready;
  assign eoi_stb    = wr_even & ready & (wdata[7:5] == 3'b001) & (wdata[4:3] == 2'b00);
  assign cfg_unused = ^{wdata[2], wdata[IDX_W-1:0]};

  always_comb begin
    st_n        = st_q;
    level_n     = level_q;
    single_n    = single_q;
    need_opts_n = need_opts_q;
    aeoi_n      = aeoi_q;
    base_n      = base_q;
    smap_n      = smap_q;
    if (start_stb) begin
      st_n        = ST_BASE;
      level_n     = wdata[3];
      single_n    = wdata[1];
      need_opts_n = wdata[0];
      aeoi_n      = 1'b0;
      smap_n      = '0;
    end else if (wr_odd) begin
      unique case (st_q)
        ST_BASE: begin
          base_n = wdata[CMD_W-1:IDX_W];
          if (!single_q)       st_n = ST_SLAVE;
          else if (need_opts_q) st_n = ST_OPTS;
          else                 st_n = ST_RUN;
        end
        ST_SLAVE: begin
          smap_n = wdata[NUM_IN-1:0];
          st_n   = need_opts_q ? ST_OPTS : ST_RUN;
        end
        ST_OPTS: begin
          aeoi_n = wdata[1];
          st_n   = ST_RUN;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_WAIT1;
      level_q     <= 1'b0;
      single_q    <= 1'b0;
      need_opts_q <= 1'b0;
      aeoi_q      <= 1'b0;
      base_q      <= '0;
      smap_q      <= '0;
    end else begin
      st_q        <= st_n;
      level_q     <= level_n;
      single_q    <= single_n;
      need_opts_q <= need_opts_n;
      aeoi_q      <= aeoi_n;
      base_q      <= base_n;
      smap_q      <= smap_n;
    end
  end

  assign level_mode = level_q;
  assign cascade    = ~single_q;
  assign aeoi       = aeoi_q;
  assign base       = base_q;
  assign slave_map  = smap_q;

  AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    start_stb |=> (st_q == ST_BASE)); // R2
  AST_SEQ_NO_SKIP_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT1) && !start_stb |=> (st_q == ST_WAIT1)); // R1
endmodule

// File: rtl/pic_req_latch.sv
module pic_req_latch #(
  parameter int NUM_IN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] irq_in,
  input  logic              level_mode,
  input  logic              clr_all,
  input  logic [NUM_IN-1:0] take_clr,
  output logic [NUM_IN-1:0] irr
);
  logic [NUM_IN-1:0] prev_q;
  logic [NUM_IN-1:0] irr_q, irr_n;
  logic [NUM_IN-1:0] rise;

  assign rise = irq_in & ~prev_q;

  always_comb begin
    if (clr_all)         irr_n = '0;
    else if (level_mode) irr_n = irq_in;
    else                 irr_n = (irr_q & ~take_clr) | rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      irr_q  <= '0;
    end else begin
      prev_q <= irq_in;
      irr_q  <= irr_n;
    end
  end

  assign irr = irr_q;

  AST_EDGE_NEEDS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !level_mode && !clr_all && (irr_q == '0) && (rise == '0) |=> (irr_q == '0)); // R6
endmodule

// File: rtl/pic_prio.sv
module pic_prio #(
  parameter int NUM_IN = 8,
  parameter int IDX_W  = 3
) (
  input  logic [NUM_IN-1:0] req,
  input  logic [NUM_IN-1:0] isr,
  output logic [NUM_IN-1:0] grant,
  output logic [IDX_W-1:0]  idx,
  output logic              hit
);
  logic [NUM_IN-1:0] blocked;
  logic [NUM_IN-1:0] elig;

  for (genvar i = 0; i < NUM_IN; i++) begin : g_block
    assign blocked[i] = |isr[i:0];
  end

  assign elig = req & ~blocked;
  assign hit  = |elig;

  always_comb begin
    grant = '0;
    idx   = '0;
    for (int i = NUM_IN - 1; i >= 0; i--) begin
      if (elig[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        idx      = IDX_W'(i);
      end
    end
  end

  always_comb begin
    AST_GRANT_ONEHOT: assert ($onehot0(grant)); // R8
  end
endmodule

// File: rtl/prog_irq_ctrl.sv
module prog_irq_ctrl
  import pic_pkg::*;
#(
  parameter int NUM_IN = 8,
  parameter int VEC_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              addr,
  input  logic [7:0]        wdata,
  input  logic [NUM_IN-1:0] irq_in,
  input  logic              ack,
  output logic              int_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic              vec_valid,
  output logic              cas_sel
);
  localparam int IDX_W  = $clog2(NUM_IN);
  localparam int BASE_W = VEC_W - IDX_W;

  logic              ready, start_stb, mask_stb, eoi_stb;
  logic              level_mode, cascade, aeoi;
  logic [BASE_W-1:0] base;
  logic [NUM_IN-1:0] slave_map;
  logic [NUM_IN-1:0] irr, grant;
  logic [IDX_W-1:0]  win_idx;
  logic              hit, take;

  logic [NUM_IN-1:0] imr_q, imr_n;
  logic [NUM_IN-1:0] isr_q, isr_n;
  logic [VEC_W-1:0]  vec_q, vec_n;
  logic              vv_q, cas_q, cas_n;

  pic_init_seq #(.NUM_IN(NUM_IN), .BASE_W(BASE_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .ready(ready), .start_stb(start_stb), .mask_stb(mask_stb), .eoi_stb(eoi_stb),
    .level_mode(level_mode), .cascade(cascade), .aeoi(aeoi),
    .base(base), .slave_map(slave_map)
  );

  pic_req_latch #(.NUM_IN(NUM_IN)) req_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .level_mode(level_mode),
    .clr_all(start_stb), .take_clr(take ? grant : '0), .irr(irr)
  );

  pic_prio #(.NUM_IN(NUM_IN), .IDX_W(IDX_W)) prio_i (
    .req(irr & ~imr_q), .isr(isr_q), .grant(grant), .idx(win_idx), .hit(hit)
  );

  assign int_o = ready & hit;
  assign take  = ack & int_o;

  always_comb begin
    imr_n = imr_q;
    isr_n = isr_q;
    vec_n = vec_q;
    cas_n = 1'b0;
    if (start_stb) begin
      imr_n = '0;
      isr_n = '0;
    end else begin
      if (mask_stb) imr_n = wdata[NUM_IN-1:0];
      if (eoi_stb)  isr_n = isr_n & (isr_n - 1'b1);
      if (take) begin
        if (!aeoi) isr_n = isr_n | grant;
        vec_n = {base, win_idx};
        cas_n = cascade & |(grant & slave_map);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imr_q <= '0;
      isr_q <= '0;
      vec_q <= '0;
      vv_q  <= 1'b0;
      cas_q <= 1'b0;
    end else begin
      imr_q <= imr_n;
      isr_q <= isr_n;
      vec_q <= vec_n;
      vv_q  <= take;
      cas_q <= cas_n;
    end
  end

  assign vec_o     = vec_q;
  assign vec_valid = vv_q;
  assign cas_sel   = cas_q;

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start_stb |=> (isr_q == '0) && (imr_q == '0)); // R2
  AST_VEC_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (vec_o[VEC_W-1:IDX_W] == base)); // R4
  AST_NO_SPURIOUS_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    ack && !int_o |=> !vec_valid); // R9
  AST_ACK_GIVES_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    ack && int_o |=> vec_valid); // R9
  AST_AEOI_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    aeoi |-> (isr_q == '0)); // R10
  AST_EOI_DROPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_stb && (isr_q != '0) && !take |=> ($countones(isr_q) == $countones($past(isr_q)) - 1)); // R11
  AST_CAS_WITH_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    cas_sel |-> vec_valid); // R12
endmodule

// File: tb/prog_irq_ctrl_tb.sv
module prog_irq_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, addr, ack;
  logic [7:0] wdata, irq_in;
  logic       int_o, vec_valid, cas_sel;
  logic [7:0] vec_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic [8:0] exp_q[$];

  always #5 clk = ~clk;

  prog_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .irq_in(irq_in), .ack(ack), .int_o(int_o), .vec_o(vec_o),
    .vec_valid(vec_valid), .cas_sel(cas_sel)
  );

  task automatic check(input logic [8:0] act, input logic [8:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_irq(input logic [7:0] v);
    irq_in = v;
    @(negedge clk);
  endtask

  task automatic do_ack(input logic [7:0] v, input logic c);
    exp_q.push_back({c, v});
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  always @(negedge clk) begin
    if (vec_valid) begin
      if (exp_q.size() == 0) begin
        check({cas_sel, vec_o}, 9'h1FF, "R9 unexpected vector");
      end else begin
        check({cas_sel, vec_o}, exp_q.pop_front(), "R4/R9/R12 vector");
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; addr = 1'b0; wdata = '0; irq_in = '0; ack = 1'b0;
    repeat (3) @(negedge clk);
    check({6'd0, int_o, vec_valid, cas_sel}, 9'd0, "R1 reset outputs");
    rst_n = 1'b1;
    @(negedge clk);

    // R1: not initialized yet, requests never reach int_o
    wr(1'b1, 8'h00);
    set_irq(8'h08);
    check({8'd0, int_o}, 9'd0, "R1 silent before init");
    set_irq(8'h00);

    // Edge, single, options requested: ICW1 13h, base 40h, options 01h
    wr(1'b0, 8'h13);
    wr(1'b1, 8'h40);
    set_irq(8'h20);
    check({8'd0, int_o}, 9'd0, "R3 held low during init");
    wr(1'b1, 8'h01);
    check({8'd0, int_o}, 9'd1, "R3 raised after last word");
    do_ack(8'h45, 1'b0);
    check({8'd0, int_o}, 9'd0, "R9 int drops after ack");
    wr(1'b0, 8'h20);
    check({8'd0, int_o}, 9'd0, "R6 held line does not re-request");
    set_irq(8'h00);

    // R8 fixed priority and nesting
    set_irq(8'h44);
    check({8'd0, int_o}, 9'd1, "R8 request pending");
    do_ack(8'h42, 1'b0);
    check({8'd0, int_o}, 9'd0, "R8 lower request blocked by in-service");
    set_irq(8'h46);
    check({8'd0, int_o}, 9'd1, "R8 higher request nests");
    do_ack(8'h41, 1'b0);
    wr(1'b0, 8'h20);
    check({8'd0, int_o}, 9'd0, "R11 only highest in-service cleared");
    wr(1'b0, 8'h20);
    check({8'd0, int_o}, 9'd1, "R11 second eoi releases input 6");
    do_ack(8'h46, 1'b0);
    wr(1'b0, 8'h20);
    set_irq(8'h00);

    // R5 masking
    wr(1'b1, 8'h10);
    set_irq(8'h10);
    check({8'd0, int_o}, 9'd0, "R5 masked input silent");
    wr(1'b1, 8'h00);
    check({8'd0, int_o}, 9'd1, "R5 held request after unmask");
    do_ack(8'h44, 1'b0);
    wr(1'b0, 8'h20);
    set_irq(8'h00);

    // R9 acknowledge with no interrupt
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    check({8'd0, vec_valid}, 9'd0, "R9 spurious ack ignored");

    // Level, cascade, options with auto EOI: ICW1 19h, base 80h, map 04h, options 02h
    wr(1'b1, 8'hFF);
    wr(1'b0, 8'h19);
    wr(1'b1, 8'h80);
    check({8'd0, int_o}, 9'd0, "R3 waits for slave map");
    wr(1'b1, 8'h04);
    wr(1'b1, 8'h02);
    set_irq(8'h04);
    check({8'd0, int_o}, 9'd1, "R2 mask cleared by restart, R7 level");
    do_ack(8'h82, 1'b1);
    check({8'd0, int_o}, 9'd1, "R10 auto eoi leaves level request live");
    set_irq(8'h00);
    check({8'd0, int_o}, 9'd0, "R7 request follows level low");
    set_irq(8'h08);
    do_ack(8'h83, 1'b0);
    set_irq(8'h00);

    // Single, no options word: ICW1 12h, base 20h
    wr(1'b0, 8'h12);
    wr(1'b1, 8'h20);
    set_irq(8'h01);
    check({8'd0, int_o}, 9'd1, "R3 options skipped, running");
    do_ack(8'h20, 1'b0);
    set_irq(8'h03);
    check({8'd0, int_o}, 9'd0, "R10 options default no auto eoi");
    wr(1'b0, 8'h20);
    check({8'd0, int_o}, 9'd1, "R11 eoi releases input 1");
    do_ack(8'h21, 1'b0);
    set_irq(8'h00);
    repeat (3) @(negedge clk);

    check(9'(exp_q.size()), 9'd0, "R9 every ack returned a vector");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule